// File: doc/BRIEF.md
# Cache Response Issue Controller

This block sits where a shared cache hands responses back to its cores. It takes one response descriptor at a time over a valid/ready handshake. The descriptor holds the destination core, a 4-bit return type, a thread id, a set of header flags, an atomic marker and a 128-bit payload. Before anything is issued, the header is checked against the return-type rules. A descriptor that breaks a rule is consumed, answered with a one-cycle reject pulse, and never reaches the crossbar.

A legal descriptor raises a one-hot request toward its core. The full 146-bit packet (valid bit, header, payload) follows one clock later. An atomic response goes out as two request beats on consecutive cycles to the same core. The second beat repeats the header and payload with the second-beat flag (bit 129) set. While the second beat goes out, the input is not ready.

Each core returns one grant per request beat. A per-core credit counter tracks outstanding beats and holds the input off once that core has 64 outstanding. A grant that arrives while the core's counter is zero sets a sticky protocol error.

Top module: `rsp_issue_ctrl`

## Requirements
- R1: `out_req` has at most one bit set. Bit i is high exactly in the cycle after a legal descriptor for core i is accepted, or in the cycle after the first beat of an atomic to core i.
- R2: In the cycle after `out_req` is non-zero, `out_pkt[145]` is 1 and the packet carries that beat's header and payload. The fields are: [144:141] return type, [140] cache-miss, [139:138] error code, [137] non-cacheable, [136:134] thread, [133] way-valid, [132:131] translation-unit id, [130] four-byte fetch, [129] second beat, [128] prefetch, [127:0] payload. In every other cycle `out_pkt` is all zero.
- R3: Only these return types are legal: 0000 load, 0001 instruction fill, 0010 stream load, 0011 eviction invalidate, 0100 store ack, 0101 translation load, 0110 stream store ack, 1100 cache error. Any other type is rejected.
- R4: A descriptor is rejected when its non-cacheable bit is 0 and any of these holds: the type is 0101; the type is 0000 with prefetch set; the type is 0000 or 0100 with the second-beat flag or the atomic marker set.
- R5: A descriptor of type 0011 or 1100 with prefetch set is rejected when its cache-miss bit is 0.
- R6: An accepted legal atomic raises `out_atom` with its first request. The next cycle repeats the same one-hot request with `out_atom` low, and the second packet has bit 129 set.
- R7: `in_ready` is 0 in the cycle in which the second beat of an atomic is requested.
- R8: Each core's outstanding count rises by one per request beat and falls by one per grant. `in_ready` is 0 whenever the addressed core's count plus the beats the descriptor needs (2 for atomic, 1 otherwise) would exceed 64.
- R9: A rejected descriptor is accepted (`in_ready` high), raises `reject` for exactly the following cycle, and produces no request.
- R10: A grant to a core whose count is zero leaves that count at zero and sets `proto_err`, which stays set until reset.
- R11: While `rst_n` is low at a clock edge, the block clears all counts, any pending second beat, `out_req`, `out_atom`, `out_pkt`, `reject` and `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor taken on this edge when valid |
| in_core | input | 3 | Destination core |
| in_rtype | input | 4 | Return type |
| in_l2miss | input | 1 | Cache-miss flag |
| in_err | input | 2 | Error code |
| in_nc | input | 1 | Non-cacheable flag |
| in_thread | input | 3 | Thread id |
| in_wayv | input | 1 | Way-valid flag |
| in_mmu | input | 2 | Translation-unit id |
| in_f4b | input | 1 | Four-byte fetch flag |
| in_second | input | 1 | Second-beat flag |
| in_pf | input | 1 | Prefetch flag |
| in_atomic | input | 1 | Issue as two beats |
| in_payload | input | 128 | Response data |
| out_req | output | 8 | One-hot request per core |
| out_atom | output | 1 | First beat of an atomic pair |
| out_pkt | output | 146 | Packet, one cycle behind the request |
| grant | input | 8 | Per-core grant |
| reject | output | 1 | Descriptor refused (one-cycle pulse) |
| proto_err | output | 1 | Sticky grant-without-request error |

## Verification
`in_ready` is combinational from the current counts and the presented descriptor. The bench therefore checks it a moment after driving the inputs, before the edge. `out_req`, `out_atom` and `reject` are due one edge after acceptance, and the packet is due two edges after acceptance. For an atomic, the second request is due two edges after acceptance and the second packet three. `proto_err` is due one edge after the offending grant. The bench keeps a cycle-stepped model that is advanced once per edge. It compares every output at each falling edge, so each result is checked exactly in the cycle it is due and never earlier or later.

// File: rtl/rsp_issue_pkg.sv
package rsp_issue_pkg;

  localparam logic [3:0] RT_LOAD  = 4'b0000;
  localparam logic [3:0] RT_IFILL = 4'b0001;
  localparam logic [3:0] RT_STRLD = 4'b0010;
  localparam logic [3:0] RT_EVICT = 4'b0011;
  localparam logic [3:0] RT_STACK = 4'b0100;
  localparam logic [3:0] RT_XLATE = 4'b0101;
  localparam logic [3:0] RT_STRST = 4'b0110;
  localparam logic [3:0] RT_CERR  = 4'b1100;

  // header in packet bit order, most significant field first
  typedef struct packed {
    logic [3:0] rtype;
    logic       l2miss;
    logic [1:0] err;
    logic       nc;
    logic [2:0] thr;
    logic       wayv;
    logic [1:0] mmu;
    logic       f4b;
    logic       second;
    logic       pf;
  } hdr_t;

  function automatic logic type_known(logic [3:0] t);
    case (t)
      RT_LOAD, RT_IFILL, RT_STRLD, RT_EVICT,
      RT_STACK, RT_XLATE, RT_STRST, RT_CERR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic rules_ok(hdr_t h);
    logic want_nc, want_miss;
    want_nc = (h.rtype == RT_XLATE) ||
              (h.rtype == RT_LOAD && h.pf) ||
              ((h.rtype == RT_LOAD || h.rtype == RT_STACK) && h.second);
    want_miss = (h.rtype == RT_EVICT || h.rtype == RT_CERR) && h.pf;
    return (!want_nc || h.nc) && (!want_miss || h.l2miss);
  endfunction

  function automatic logic has_room(int unsigned cnt, int unsigned need,
                                    int unsigned cap);
    return (cnt + need) <= cap;
  endfunction

endpackage

// File: rtl/rsp_hdr_check.sv
module rsp_hdr_check
  import rsp_issue_pkg::*;
(
  input  hdr_t hdr_i,
  input  logic atomic_i,
  output logic legal_o
);
  hdr_t hdr_b2;
  logic type_ok, first_ok, second_ok;

  always_comb begin
    hdr_b2        = hdr_i;
    hdr_b2.second = 1'b1;
  end

  assign type_ok   = type_known(hdr_i.rtype);
  assign first_ok  = rules_ok(hdr_i);
  assign second_ok = !atomic_i || rules_ok(hdr_b2);
  assign legal_o   = type_ok && first_ok && second_ok;
endmodule

// File: rtl/rsp_credit_bank.sv
module rsp_credit_bank #(
  parameter int NUM_CORES = 8,
  parameter int CNT_W     = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CORES-1:0]       inc_vec,
  input  logic [NUM_CORES-1:0]       grant_vec,
  output logic [NUM_CORES*CNT_W-1:0] cnt_o,
  output logic [NUM_CORES-1:0]       underflow_o
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [CNT_W-1:0] cnt_q;
    logic             dec;

    assign dec            = grant_vec[i] && (cnt_q != '0);
    assign underflow_o[i] = grant_vec[i] && (cnt_q == '0);
    assign cnt_o[i*CNT_W +: CNT_W] = cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(inc_vec[i]) - CNT_W'(dec);
    end
  end
endmodule

// File: rtl/rsp_beat_seq.sv
module rsp_beat_seq
  import rsp_issue_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int PAYLOAD_W = 128,
  parameter int CORE_W    = 3,
  parameter int PKT_W     = 146
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CORE_W-1:0]    core_i,
  input  logic                 atomic_i,
  input  hdr_t                 hdr_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic [NUM_CORES-1:0] req_o,
  output logic                 atom_o,
  output logic [PKT_W-1:0]     pkt_o,
  output logic                 beat2_o,
  output logic [NUM_CORES-1:0] issue_vec_o
);
  localparam int BODY_W = PKT_W - 1;

  function automatic logic [NUM_CORES-1:0] dec_core(logic [CORE_W-1:0] c);
    logic [NUM_CORES-1:0] v;
    v    = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  logic [NUM_CORES-1:0] req_q;
  logic                 atom_q, b2_q;
  logic [BODY_W-1:0]    stage_q, save_q;
  logic [CORE_W-1:0]    save_core_q;
  logic [PKT_W-1:0]     pkt_q;
  hdr_t                 hdr_b2;

  always_comb begin
    hdr_b2        = hdr_i;
    hdr_b2.second = 1'b1;
  end

  always_comb begin
    if (start_i)   issue_vec_o = dec_core(core_i);
    else if (b2_q) issue_vec_o = dec_core(save_core_q);
    else           issue_vec_o = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q       <= '0;
      atom_q      <= 1'b0;
      b2_q        <= 1'b0;
      stage_q     <= '0;
      save_q      <= '0;
      save_core_q <= '0;
      pkt_q       <= '0;
    end else begin
      pkt_q <= (|req_q) ? {1'b1, stage_q} : '0;
      if (start_i) begin
        req_q       <= dec_core(core_i);
        atom_q      <= atomic_i;
        b2_q        <= atomic_i;
        stage_q     <= {hdr_i, payload_i};
        save_q      <= {hdr_b2, payload_i};
        save_core_q <= core_i;
      end else if (b2_q) begin
        req_q   <= dec_core(save_core_q);
        atom_q  <= 1'b0;
        b2_q    <= 1'b0;
        stage_q <= save_q;
      end else begin
        req_q  <= '0;
        atom_q <= 1'b0;
      end
    end
  end

  assign req_o   = req_q;
  assign atom_o  = atom_q;
  assign pkt_o   = pkt_q;
  assign beat2_o = b2_q;
endmodule

// File: rtl/rsp_issue_ctrl.sv
module rsp_issue_ctrl
  import rsp_issue_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int PAYLOAD_W = 128,
  parameter int MAX_OUT   = 64,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int CNT_W    = $clog2(MAX_OUT + 1),
  localparam int HDR_W    = $bits(hdr_t),
  localparam int PKT_W    = PAYLOAD_W + HDR_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CORE_W-1:0]    in_core,
  input  logic [3:0]           in_rtype,
  input  logic                 in_l2miss,
  input  logic [1:0]           in_err,
  input  logic                 in_nc,
  input  logic [2:0]           in_thread,
  input  logic                 in_wayv,
  input  logic [1:0]           in_mmu,
  input  logic                 in_f4b,
  input  logic                 in_second,
  input  logic                 in_pf,
  input  logic                 in_atomic,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic [NUM_CORES-1:0] out_req,
  output logic                 out_atom,
  output logic [PKT_W-1:0]     out_pkt,
  input  logic [NUM_CORES-1:0] grant,
  output logic                 reject,
  output logic                 proto_err
);
  hdr_t                       hdr_in;
  logic                       hdr_legal;
  logic                       accept, issue_go, room, beat2_pend;
  logic [CNT_W-1:0]           cnt_sel;
  logic [NUM_CORES*CNT_W-1:0] cnt_flat;
  logic [NUM_CORES-1:0]       issue_vec, underflow_vec;
  logic                       rej_q, perr_q;

  assign hdr_in = {in_rtype, in_l2miss, in_err, in_nc, in_thread,
                   in_wayv, in_mmu, in_f4b, in_second, in_pf};

  rsp_hdr_check u_hdr (
    .hdr_i    (hdr_in),
    .atomic_i (in_atomic),
    .legal_o  (hdr_legal)
  );

  assign cnt_sel  = cnt_flat[in_core*CNT_W +: CNT_W];
  assign room     = has_room(32'(cnt_sel), in_atomic ? 32'd2 : 32'd1,
                             32'(MAX_OUT));
  assign in_ready = !beat2_pend && room;
  assign accept   = in_valid && in_ready;
  assign issue_go = accept && hdr_legal;

  rsp_beat_seq #(
    .NUM_CORES (NUM_CORES),
    .PAYLOAD_W (PAYLOAD_W),
    .CORE_W    (CORE_W),
    .PKT_W     (PKT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (issue_go),
    .core_i      (in_core),
    .atomic_i    (in_atomic),
    .hdr_i       (hdr_in),
    .payload_i   (in_payload),
    .req_o       (out_req),
    .atom_o      (out_atom),
    .pkt_o       (out_pkt),
    .beat2_o     (beat2_pend),
    .issue_vec_o (issue_vec)
  );

  rsp_credit_bank #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W)
  ) u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_vec     (issue_vec),
    .grant_vec   (grant),
    .cnt_o       (cnt_flat),
    .underflow_o (underflow_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rej_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      rej_q  <= accept && !hdr_legal;
      perr_q <= perr_q || (|underflow_vec);
    end
  end

  assign reject    = rej_q;
  assign proto_err = perr_q;
endmodule

// File: rtl/rsp_issue_ctrl_chk.sv
module rsp_issue_ctrl_chk
  import rsp_issue_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int PAYLOAD_W = 128,
  parameter int MAX_OUT   = 64,
  parameter int CNT_W     = 7,
  parameter int PKT_W     = 146
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_ready,
  input logic [NUM_CORES-1:0]       out_req,
  input logic                       out_atom,
  input logic [PKT_W-1:0]           out_pkt,
  input logic                       reject,
  input logic                       proto_err,
  input logic [NUM_CORES*CNT_W-1:0] cnt_flat,
  input logic [NUM_CORES-1:0]       underflow_vec
);
  hdr_t pkt_hdr;
  assign pkt_hdr = out_pkt[PKT_W-2:PAYLOAD_W];

  // R1
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_req));

  // R2
  pkt_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_req) |=> out_pkt[PKT_W-1]);

  // R2
  pkt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|out_req) |=> (out_pkt == '0));

  // R3
  pkt_type_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pkt[PKT_W-1] |-> type_known(pkt_hdr.rtype));

  // R4
  pkt_rules_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pkt[PKT_W-1] |-> rules_ok(pkt_hdr));

  // R6
  atom_second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_atom |=> (out_req == $past(out_req)) && !out_atom);

  // R7
  atom_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_atom |-> !in_ready);

  // R9
  reject_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (out_req == '0));

  // R10
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R10
  perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past(|underflow_vec));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_cap
    // R8
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_flat[i*CNT_W +: CNT_W]) <= MAX_OUT);
  end
endmodule

bind rsp_issue_ctrl rsp_issue_ctrl_chk #(
  .NUM_CORES (NUM_CORES),
  .PAYLOAD_W (PAYLOAD_W),
  .MAX_OUT   (MAX_OUT),
  .CNT_W     (CNT_W),
  .PKT_W     (PKT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_req       (out_req),
  .out_atom      (out_atom),
  .out_pkt       (out_pkt),
  .reject        (reject),
  .proto_err     (proto_err),
  .cnt_flat      (cnt_flat),
  .underflow_vec (underflow_vec)
);

// File: tb/rsp_issue_ctrl_test.sv
module rsp_issue_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst_n;
  logic         b_valid, b_l2miss, b_nc, b_wayv, b_f4b, b_second, b_pf, b_atomic;
  logic [2:0]   b_core, b_thr;
  logic [3:0]   b_type;
  logic [1:0]   b_err, b_mmu;
  logic [127:0] b_pay;
  logic [7:0]   b_grant;
  logic         in_ready, out_atom, reject, proto_err;
  logic [7:0]   out_req;
  logic [145:0] out_pkt;

  rsp_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(in_ready),
    .in_core(b_core), .in_rtype(b_type), .in_l2miss(b_l2miss), .in_err(b_err),
    .in_nc(b_nc), .in_thread(b_thr), .in_wayv(b_wayv), .in_mmu(b_mmu),
    .in_f4b(b_f4b), .in_second(b_second), .in_pf(b_pf), .in_atomic(b_atomic),
    .in_payload(b_pay), .out_req(out_req), .out_atom(out_atom),
    .out_pkt(out_pkt), .grant(b_grant), .reject(reject), .proto_err(proto_err)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [7:0]   m_req;
  logic         m_atom, m_b2, m_rej, m_perr;
  logic [144:0] m_stage, m_save;
  logic [2:0]   m_save_core;
  logic [145:0] m_pkt;
  string        m_rej_tag;
  int           m_cnt [8];

  task automatic chk(bit ok, string tag, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] bhdr(logic second);
    logic [16:0] h;
    h[0] = b_pf;        h[1] = second;      h[2] = b_f4b;
    h[4:3] = b_mmu;     h[5] = b_wayv;      h[8:6] = b_thr;
    h[9] = b_nc;        h[11:10] = b_err;   h[12] = b_l2miss;
    h[16:13] = b_type;
    return h;
  endfunction

  function automatic string why_bad();
    if (!(b_type inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hC}))
      return "R3";
    if (!b_nc) begin
      if (b_type == 4'h5) return "R4";
      if (b_type == 4'h0 && b_pf) return "R4";
      if ((b_type == 4'h0 || b_type == 4'h4) && (b_second || b_atomic)) return "R4";
    end
    if ((b_type == 4'h3 || b_type == 4'hC) && b_pf && !b_l2miss) return "R5";
    return "";
  endfunction

  function automatic logic m_ready();
    return !m_b2 && ((m_cnt[b_core] + (b_atomic ? 2 : 1)) <= 64);
  endfunction

  task automatic model_reset();
    m_req = '0; m_atom = 0; m_b2 = 0; m_rej = 0; m_perr = 0;
    m_stage = '0; m_save = '0; m_save_core = '0; m_pkt = '0; m_rej_tag = "";
    foreach (m_cnt[i]) m_cnt[i] = 0;
  endtask

  // one clock: check ready, advance model, compare outputs at next negedge
  task automatic tick();
    logic [7:0] n_req; logic n_atom, n_b2, n_rej; logic [145:0] n_pkt;
    string rsn; logic acc;
    #1;
    chk(in_ready == m_ready(), b_atomic ? "R7/R8 ready" : "R8 ready", 160'(in_ready), 160'(m_ready()));
    rsn = why_bad();
    acc = b_valid && m_ready();
    n_pkt = (m_req != 0) ? {1'b1, m_stage} : '0;
    n_req = '0; n_atom = 0; n_b2 = 0;
    n_rej = acc && (rsn != "");
    if (acc && rsn == "") begin
      n_req = 8'(1) << b_core; n_atom = b_atomic; n_b2 = b_atomic;
      m_stage = {bhdr(b_second), b_pay};
      m_save = {bhdr(1'b1), b_pay}; m_save_core = b_core;
    end else if (m_b2) begin
      n_req = 8'(1) << m_save_core; m_stage = m_save;
    end
    for (int i = 0; i < 8; i++) begin
      if (b_grant[i]) begin
        if (m_cnt[i] > 0) m_cnt[i]--; else m_perr = 1;
      end
      if (n_req[i]) m_cnt[i]++;
    end
    m_req = n_req; m_atom = n_atom; m_b2 = n_b2; m_pkt = n_pkt;
    m_rej = n_rej; m_rej_tag = rsn;
    if (!rst_n) model_reset();
    @(posedge clk);
    @(negedge clk);
    chk(out_req == m_req, "R1 req", 160'(out_req), 160'(m_req));
    chk(out_atom == m_atom, "R6 atom", 160'(out_atom), 160'(m_atom));
    chk(out_pkt == m_pkt, "R2 pkt", 160'(out_pkt), 160'(m_pkt));
    chk(reject == m_rej, m_rej ? {m_rej_tag, "/R9 reject"} : "R9 reject", 160'(reject), 160'(m_rej));
    chk(proto_err == m_perr, "R10 proto_err", 160'(proto_err), 160'(m_perr));
  endtask

  task automatic base_desc(logic [2:0] core, logic [3:0] t);
    b_core = core; b_type = t; b_l2miss = 0; b_err = 2'd1; b_nc = 1;
    b_thr = 3'd5; b_wayv = 1; b_mmu = 2'd2; b_f4b = 0; b_second = 0;
    b_pf = 0; b_atomic = 0;
    b_pay = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic rand_desc();
    int r;
    r = $urandom % 10;
    base_desc(3'($urandom % 8), 4'h0);
    if (r < 8) begin
      case ($urandom % 8)
        0: b_type = 4'h0; 1: b_type = 4'h1; 2: b_type = 4'h2; 3: b_type = 4'h3;
        4: b_type = 4'h4; 5: b_type = 4'h5; 6: b_type = 4'h6; default: b_type = 4'hC;
      endcase
    end else begin
      b_type = 4'h7 + 4'($urandom % 5);
      if (b_type == 4'hC) b_type = 4'hF;
    end
    b_l2miss = ($urandom % 4) != 0; b_nc = ($urandom % 4) != 0;
    b_err = 2'($urandom); b_thr = 3'($urandom); b_wayv = 1'($urandom);
    b_mmu = 2'($urandom); b_f4b = 1'($urandom); b_second = ($urandom % 4) == 0;
    b_pf = 1'($urandom); b_atomic = ($urandom % 5) == 0;
  endtask

  task automatic drain();
    b_valid = 0;
    for (int k = 0; k < 200; k++) begin
      logic [7:0] g;
      g = '0;
      for (int i = 0; i < 8; i++) if (m_cnt[i] > 0) g[i] = 1;
      if (g == 0 && !m_b2) break;
      b_grant = g;
      tick();
    end
    b_grant = '0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; b_valid = 0; b_grant = '0;
    base_desc(3'd0, 4'h0);
    model_reset();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_req == 0 && out_atom == 0 && reject == 0 && proto_err == 0,
        "R11 reset outputs", 160'({out_req, out_atom, reject, proto_err}), 160'(0));
    chk(out_pkt == 0, "R11 reset pkt", 160'(out_pkt), 160'(0));
    rst_n = 1;

    // rejections, one per rule
    base_desc(3'd1, 4'hF); b_valid = 1; tick();            // R3
    b_valid = 0; tick();
    chk(reject == 0, "R9 pulse length", 160'(reject), 160'(0));
    base_desc(3'd1, 4'h5); b_nc = 0; b_valid = 1; tick();  // R4 translation load
    base_desc(3'd1, 4'h0); b_nc = 0; b_pf = 1; tick();     // R4 prefetch load
    base_desc(3'd1, 4'h4); b_nc = 0; b_atomic = 1; tick(); // R4 atomic
    base_desc(3'd1, 4'h3); b_pf = 1; tick();               // R5 eviction
    base_desc(3'd2, 4'hC); b_pf = 1; b_l2miss = 1; tick(); // R5 legal
    // legal atomic to core 6, held valid during the second beat
    base_desc(3'd6, 4'h0); b_atomic = 1; tick();
    chk(out_req == 8'h40 && out_atom, "R6 first beat", 160'({out_req, out_atom}), 160'({8'h40, 1'b1}));
    #1 chk(in_ready == 0, "R7 ready in beat two", 160'(in_ready), 160'(0));
    tick();
    b_valid = 0; tick();
    chk(out_pkt[129] == 1, "R6 second flag", 160'(out_pkt[129]), 160'(1));
    tick();
    drain();

    // fill core 3 to the cap with no grants
    base_desc(3'd3, 4'h1); b_valid = 1;
    repeat (70) tick();
    #1 chk(in_ready == 0, "R8 cap stall", 160'(in_ready), 160'(0));
    b_atomic = 1; b_core = 3'd4;
    #1 chk(in_ready == 1, "R8 other core free", 160'(in_ready), 160'(1));
    drain();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      rand_desc();
      b_valid = ($urandom % 4) != 0;
      b_grant = '0;
      for (int i = 0; i < 8; i++)
        if (m_cnt[i] > 0 && ($urandom % 3) == 0) b_grant[i] = 1;
      tick();
    end
    drain();

    // grant with nothing outstanding
    b_grant = 8'h01; tick(); b_grant = '0; tick();
    chk(proto_err == 1, "R10 grant at zero", 160'(proto_err), 160'(1));

    // counts cleared by reset
    base_desc(3'd5, 4'h2); b_valid = 1;
    repeat (10) tick();
    b_valid = 0; rst_n = 0; tick(); rst_n = 1;
    chk(proto_err == 0, "R11 reset clears error", 160'(proto_err), 160'(0));
    b_grant = 8'h20; tick(); b_grant = '0; tick();
    chk(proto_err == 1, "R11 counts cleared", 160'(proto_err), 160'(1));

    summary();
  end
endmodule